// File: doc/BRIEF.md
# Multiplexed-Address DRAM Sequencer with Refresh Arbitration

This block sits between a simple processor bus and an asynchronous DRAM. The processor raises a request with a full word address and a write flag, then holds them until the block returns a one-clock ready pulse. The block presents the upper half of the address as the row on a half-width address port. It lowers the row strobe, switches the same pins to the lower half as the column, and then lowers the column strobe. Every delay in this sequence is a whole number of controller clocks set by a parameter.

A free-running interval timer raises a refresh demand. The block serves it with a column-before-row cycle, so the DRAM's own row counter picks the row and the write strobe stays high. A processor request that comes in while a refresh is running waits for that refresh and its precharge to finish. After every cycle both strobes stay high for a minimum precharge time. The block does not handle data, only the strobe and address timing.

Top module: `dram_seq_ctrl`

## Requirements
- R1: While reset is held and right after it, `ras_n`, `cas_n` and `we_n` are high and `ready` is low.
- R2: An access presents `addr[ADDR_W-1:ADDR_W/2]` as the row on `dram_addr` first, then `addr[ADDR_W/2-1:0]` as the column.
- R3: The row is on `dram_addr` for T_ASR clocks before `ras_n` falls. With the request raised before clock edge 0, `ras_n` is first low T_ASR clocks after edge 0.
- R4: `dram_addr` switches to the column T_RAH clocks after `ras_n` falls, and does not switch earlier.
- R5: `cas_n` falls T_ASC clocks after the column switch. `ready` is high for exactly one clock, in the last of the T_CAS clocks during which `cas_n` is low.
- R6: For a write, `we_n` is low from the column switch to the end of the `cas_n` pulse, so it falls no later than `cas_n`. For a read, `we_n` stays high.
- R7: A refresh starts every REFI clocks while the bus is idle. In a refresh, `cas_n` falls T_CSR clocks before `ras_n`, `ras_n` stays low for T_RFR clocks, `we_n` stays high and `ready` stays low.
- R8: A request raised during a refresh gets no strobe activity until the refresh, T_RP clocks of precharge and one idle clock have passed. It then runs a normal access.
- R9: When a refresh demand and a request are both present in the same idle clock, the refresh goes first.
- R10: Before either strobe falls again, `ras_n` and `cas_n` have been high for at least T_RP clocks (T_RP of 2 or more).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Access request, held until ready |
| wr | input | 1 | 1 = write, 0 = read, valid with req |
| addr | input | ADDR_W | Full word address, valid with req |
| ready | output | 1 | One-clock completion pulse |
| dram_addr | output | ADDR_W/2 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |

## Verification
The bench measures each strobe edge and the address switch in clocks from the request. A sequencer that is off by one in any delay counter shows up as a shifted `ras_n`, column or `cas_n` edge. The bench raises a request in the first clock of a refresh. A design that lets it through would lower `ras_n` for the row while `cas_n` is still low from the refresh, or would return `ready` early. The bench also lines a request up with the clock in which the refresh demand becomes visible. A design with the wrong priority would start the access instead of the column-before-row cycle. Writes are checked for the write strobe falling before the column strobe, and refreshes for a write strobe that stays high.

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl #(
  parameter int ADDR_W = 16,
  parameter int T_ASR  = 1,
  parameter int T_RAH  = 1,
  parameter int T_ASC  = 1,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 2,
  parameter int T_CSR  = 1,
  parameter int T_RFR  = 3,
  parameter int REFI   = 1875
) (
  input  logic                 clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  output logic                ready,
  output logic [ADDR_W/2-1:0] dram_addr,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n
);
  localparam int HW = ADDR_W / 2;
  localparam int CW = 8;
  localparam int RW = $clog2(REFI + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ROW, S_RHOLD, S_COL, S_CAS, S_RCAS, S_RRAS, S_PRE
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt, dl;
  logic [RW-1:0] ref_cnt;
  logic          ref_pend;
  logic [HW-1:0] row_q, col_q;
  logic          wr_q;
  logic          done;

  assign done = (cnt == '0);

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:  if (ref_pend) nxt = S_RCAS; else if (req) nxt = S_ROW;
      S_ROW:   if (done) nxt = S_RHOLD;
      S_RHOLD: if (done) nxt = S_COL;
      S_COL:   if (done) nxt = S_CAS;
      S_CAS:   if (done) nxt = S_PRE;
      S_RCAS:  if (done) nxt = S_RRAS;
      S_RRAS:  if (done) nxt = S_PRE;
      S_PRE:   if (done) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_comb begin
    case (nxt)
      S_ROW:   dl = CW'(T_ASR - 1);
      S_RHOLD: dl = CW'(T_RAH - 1);
      S_COL:   dl = CW'(T_ASC - 1);
      S_CAS:   dl = CW'(T_CAS - 1);
      S_RCAS:  dl = CW'(T_CSR - 1);
      S_RRAS:  dl = CW'(T_RFR - 1);
      S_PRE:   dl = CW'(T_RP - 1);
      default: dl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      row_q <= '0;
      col_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt != st) cnt <= dl;
      else if (!done) cnt <= cnt - 1'b1;
      if (st == S_IDLE && nxt == S_ROW) begin
        row_q <= addr[ADDR_W-1:HW];
        col_q <= addr[HW-1:0];
        wr_q  <= wr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt  <= RW'(REFI - 1);
      ref_pend <= 1'b0;
    end else begin
      if (ref_cnt == '0) ref_cnt <= RW'(REFI - 1);
      else ref_cnt <= ref_cnt - 1'b1;
      if (ref_cnt == '0) ref_pend <= 1'b1;
      else if (st == S_IDLE && ref_pend) ref_pend <= 1'b0;
    end
  end

  assign dram_addr = (st == S_COL || st == S_CAS) ? col_q : row_q;
  assign ras_n = !(st == S_RHOLD || st == S_COL || st == S_CAS || st == S_RRAS);
  assign cas_n = !(st == S_CAS || st == S_RCAS || st == S_RRAS);
  assign we_n  = !(wr_q && (st == S_COL || st == S_CAS));
  assign ready = (st == S_CAS) && done;
endmodule

// File: rtl/dram_seq_ctrl_chk.sv
module dram_seq_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int T_ASR  = 1,
  parameter int T_RAH  = 1,
  parameter int T_ASC  = 1,
  parameter int T_RP   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ready,
  input logic [ADDR_W/2-1:0] dram_addr,
  input logic                ras_n,
  input logic                cas_n,
  input logic                we_n
);
  logic [7:0] stab, lo_ras, hi_ras, hi_cas;
  logic [ADDR_W/2-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stab <= '0; lo_ras <= '0; hi_ras <= '0; hi_cas <= '0; addr_q <= '0;
    end else begin
      addr_q <= dram_addr;
      stab   <= (dram_addr != addr_q) ? 8'd1 : (stab == 8'hFF ? stab : stab + 8'd1);
      lo_ras <= ras_n  ? 8'd0 : (lo_ras == 8'hFF ? lo_ras : lo_ras + 8'd1);
      hi_ras <= !ras_n ? 8'd0 : (hi_ras == 8'hFF ? hi_ras : hi_ras + 8'd1);
      hi_cas <= !cas_n ? 8'd0 : (hi_cas == 8'hFF ? hi_cas : hi_cas + 8'd1);
    end
  end

  assert_row_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && cas_n |-> stab >= 8'(T_ASR));
  assert_row_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n && $past(!ras_n) && (dram_addr != addr_q) |-> lo_ras >= 8'(T_RAH));
  assert_col_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && !ras_n |-> stab >= 8'(T_ASC));
  assert_ready_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !ras_n && !cas_n);
  assert_we_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> cas_n && !ras_n);
  assert_refresh_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n && ras_n |-> we_n && !ready);
  assert_ras_precharge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && cas_n |-> hi_ras >= 8'(T_RP));
  assert_cas_precharge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && ras_n |-> hi_cas >= 8'(T_RP));
endmodule

bind dram_seq_ctrl dram_seq_ctrl_chk #(
  .ADDR_W(ADDR_W), .T_ASR(T_ASR), .T_RAH(T_RAH), .T_ASC(T_ASC), .T_RP(T_RP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ready(ready), .dram_addr(dram_addr),
  .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
);

// File: tb/dram_seq_ctrl_tb_top.sv
module dram_seq_ctrl_tb_top;
  localparam int AW = 16, T_ASR = 2, T_RAH = 1, T_ASC = 2, T_CAS = 2;
  localparam int T_RP = 2, T_CSR = 1, T_RFR = 3, REFI = 120;
  localparam int NACC = T_ASR + T_RAH + T_ASC + T_CAS;
  localparam int WAIT_RDY = T_CSR + T_RFR + T_RP + 1 + NACC - 1;

  logic clk = 0, rst_n = 0, req = 0, wr = 0;
  logic [AW-1:0] addr = '0;
  logic ready, ras_n, cas_n, we_n;
  logic [AW/2-1:0] dram_addr;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  dram_seq_ctrl #(.ADDR_W(AW), .T_ASR(T_ASR), .T_RAH(T_RAH), .T_ASC(T_ASC),
    .T_CAS(T_CAS), .T_RP(T_RP), .T_CSR(T_CSR), .T_RFR(T_RFR), .REFI(REFI)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .ready(ready),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_refresh_start();
    logic pc = 1'b1;
    for (int i = 0; i < 4 * REFI; i++) begin
      @(negedge clk);
      if (!cas_n && ras_n && pc) return;
      pc = cas_n;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(ras_n && cas_n && we_n && !ready, "R1 during reset", {ras_n, cas_n, we_n, ready}, 4'b1110);
    rst_n = 1;
    @(negedge clk);
    check(ras_n && cas_n && we_n && !ready, "R1 after reset", {ras_n, cas_n, we_n, ready}, 4'b1110);
  endtask

  task automatic t_access(input bit w, input logic [AW-1:0] a);
    int i_ras = -1, i_col = -1, i_cas = -1, i_rdy = -1, n_rdy = 0;
    logic [7:0] row_at = '0;
    logic we_rh = 1'b0, we_cas = 1'b0;
    wait_refresh_start();
    repeat (8) @(negedge clk);
    req = 1; wr = w; addr = a;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (!ras_n && i_ras < 0) begin i_ras = i; row_at = dram_addr; we_rh = we_n; end
      if (!ras_n && dram_addr == a[7:0] && i_col < 0) i_col = i;
      if (!cas_n && i_cas < 0) begin i_cas = i; we_cas = we_n; end
      if (ready) begin n_rdy++; if (i_rdy < 0) i_rdy = i; req = 0; end
    end
    check(row_at == a[15:8], "R2 row first", row_at, a[15:8]);
    check(i_ras == 1 + T_ASR, "R3 ras fall", i_ras, 1 + T_ASR);
    check(i_col == 1 + T_ASR + T_RAH, "R4 column switch", i_col, 1 + T_ASR + T_RAH);
    check(i_cas == 1 + T_ASR + T_RAH + T_ASC, "R5 cas fall", i_cas, 1 + T_ASR + T_RAH + T_ASC);
    check(i_rdy == NACC, "R5 ready cycle", i_rdy, NACC);
    check(n_rdy == 1, "R5 single ready", n_rdy, 1);
    check(we_rh == 1'b1, "R6 we high on row", we_rh, 1);
    check(we_cas == !w, "R6 we at cas", we_cas, !w);
  endtask

  task automatic t_refresh();
    int i_ras = -1, n_ras = 0, i_next = -1, we_low = 0, rdy = 0;
    logic pc = 1'b0;
    wait_refresh_start();
    for (int i = 1; i <= REFI + 4; i++) begin
      @(negedge clk);
      if (!ras_n && i_ras < 0) i_ras = i;
      if (!ras_n && i < 20) n_ras++;
      if (!we_n) we_low++;
      if (ready) rdy++;
      if (!cas_n && ras_n && pc && i_next < 0) i_next = i;
      pc = cas_n;
    end
    check(i_ras == T_CSR, "R7 cas before ras", i_ras, T_CSR);
    check(n_ras == T_RFR, "R7 refresh ras width", n_ras, T_RFR);
    check(we_low == 0, "R7 we idle in refresh", we_low, 0);
    check(rdy == 0, "R7 no ready in refresh", rdy, 0);
    check(i_next == REFI, "R7 refresh interval", i_next, REFI);
  endtask

  task automatic t_mid_refresh();
    int i_rdy = -1, i_ras2 = -1, hi_cnt = 0;
    logic pr = 1'b1;
    wait_refresh_start();
    req = 1; wr = 0; addr = 16'h6D92;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (ras_n && cas_n && i_ras2 < 0 && i > T_CSR) hi_cnt++;
      if (!ras_n && pr && i > T_CSR && i_ras2 < 0) i_ras2 = i;
      pr = ras_n;
      if (ready && i_rdy < 0) begin i_rdy = i; req = 0; end
    end
    check(i_rdy == WAIT_RDY, "R8 request waits for refresh", i_rdy, WAIT_RDY);
    check(hi_cnt >= T_RP + 1 + T_ASR, "R10 precharge after refresh", hi_cnt, T_RP + 1 + T_ASR);
  endtask

  task automatic t_tie();
    int i_rdy = -1;
    wait_refresh_start();
    repeat (REFI - 1) @(negedge clk);
    req = 1; wr = 1; addr = 16'h3CC3;
    @(negedge clk);
    check(!cas_n && ras_n, "R9 refresh wins tie", {cas_n, ras_n}, 2'b01);
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (ready && i_rdy < 0) begin i_rdy = i; req = 0; end
    end
    check(i_rdy == WAIT_RDY, "R9 access after refresh", i_rdy, WAIT_RDY);
  endtask

  initial begin
    t_reset();
    t_access(1'b0, 16'hA53C);
    t_access(1'b1, 16'h1E77);
    t_refresh();
    t_mid_refresh();
    t_tie();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule